// File: doc/BRIEF.md
# Single-Cell NiMH Charge Sequencer

This block is the control state machine of a single-cell nickel-metal-hydride charger. It takes already-digitised comparator flags and decides which charge phase the cell is in. The flags report supply undervoltage, a floating timer pin, the cell voltage against three limits, and three temperature thresholds. It walks the cell through qualification, a reduced-rate precharge, fast charge with periodic cell tests, a half-length top-off and an open-ended maintenance phase. It leaves that path for fault, suspend or reset when a safety condition appears.

Phase durations are counted in seconds from a one-cycle `tick_1s` strobe. The fast-charge safety timeout is a programmable 16-bit second count. It is captured when fast charge begins, and top-off reuses half of it. The state code drives the duty-factor and status-indicator logic elsewhere in the charger. `charge_active` tells the overvoltage comparator path which limit applies.

Top module: `chgctl_top`

## Requirements
- R1: A high `uv_lock` puts the machine in state 0 (reset) on the next clock edge from any state, with priority over every other input. `rst` does the same. When `uv_lock` is low, reset moves to state 1 (presence) with every second counter cleared, so an interrupted precharge later restarts its full time limit.
- R2: When `uv_lock` is low and `tmr_open` is high, the machine enters state 8 (suspend) from any state. Releasing `tmr_open` returns it to state 1 with timers cleared.
- R3: State 1 moves to state 2 (precharge) only when `vcell_gt_open`, `temp_cold` and `temp_hot_nostart` are all low. Otherwise it stays in state 1.
- R4: State 2 moves to state 3 (fast charge) when `vcell_gt_low` is high, and `fast_tmo_s` is captured at that moment.
- R5: State 2 moves to state 7 (fault) after PRE_LIMIT seconds spent in it, or at once when `temp_hot_stop` is high.
- R6: After TEST_PERIOD seconds in state 3 the machine enters state 4 (cell test). From state 4, `ct_fail` leads to state 7, `ct_term` leads to state 5 (top-off) and `ct_pass` leads back to state 3, in that order of priority.
- R7: Once the captured timeout of seconds has been counted across states 3 and 4, state 3 moves to state 5.
- R8: State 5 moves to state 6 (maintenance) after the captured timeout shifted right by one bit, counted in seconds from entry.
- R9: A high `temp_hot_stop` in state 3 or state 5 moves the machine to state 6, not to fault.
- R10: `charge_active` is high exactly in states 2, 3, 5 and 6. In states 2, 3, 4 and 5 the machine faults (state 7) on `vcell_gt_charge` when `charge_active` is high, and on `vcell_gt_open` when it is low.
- R11: States 6 and 7 are held until `vcell_gt_charge` is high, which moves the machine to state 1. The other voltage flags are ignored there.
- R12: When a fault condition and a completion condition hold in the same cycle, the fault wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| uv_lock | input | 1 | Supply below undervoltage threshold |
| tmr_open | input | 1 | Timer-setting pin detected floating |
| vcell_gt_open | input | 1 | Cell above the open-circuit limit (1.65 V) |
| vcell_gt_charge | input | 1 | Cell above the charging limit (1.75 V) |
| vcell_gt_low | input | 1 | Cell above the depleted level (1.0 V) |
| temp_cold | input | 1 | Temperature below the start window |
| temp_hot_nostart | input | 1 | Temperature above the start window |
| temp_hot_stop | input | 1 | Temperature at the hot shutdown level |
| tick_1s | input | 1 | One-cycle pulse per second |
| fast_tmo_s | input | TMO_W | Fast-charge safety timeout in seconds |
| ct_pass | input | 1 | Cell test passed, keep fast charging |
| ct_term | input | 1 | Cell test saw -dV or flat voltage |
| ct_fail | input | 1 | Cell test saw too-high impedance or voltage |
| state_code | output | 4 | Current state (0 reset … 8 suspend) |
| charge_active | output | 1 | Charge current applied; selects the 1.75 V limit |

## Verification
The bench builds the block with PRE_LIMIT set to 12 and TEST_PERIOD set to 4, while TMO_W keeps its 16-bit default. This shortens the precharge limit and the cell-test interval to a handful of ticks. Each time limit can then be approached to one tick short of expiry and then crossed. The shorter interval also makes cell tests fall inside every fast charge, so random timeouts between 6 and 36 seconds check that the fast timer keeps counting through cell tests. The same runs check the halved top-off time, including odd timeouts.

// File: rtl/chgctl_pkg.sv
package chgctl_pkg;

    typedef enum logic [3:0] {
        ST_RESET   = 4'd0,
        ST_PRESENT = 4'd1,
        ST_PRECHG  = 4'd2,
        ST_FAST    = 4'd3,
        ST_CTEST   = 4'd4,
        ST_TOPOFF  = 4'd5,
        ST_MAINT   = 4'd6,
        ST_FAULT   = 4'd7,
        ST_SUSPEND = 4'd8
    } chg_state_e;

    typedef struct packed {
        logic uv;
        logic tmr_float;
        logic v_open;
        logic v_charge;
        logic v_low;
        logic t_cold;
        logic t_hot_ns;
        logic t_hot_stop;
    } sense_t;

    typedef struct packed {
        logic pass;
        logic term;
        logic fail;
    } ctest_t;

    // States in which the overvoltage check is armed
    function automatic logic is_charging(chg_state_e s);
        return s inside {ST_PRECHG, ST_FAST, ST_CTEST, ST_TOPOFF};
    endfunction

    // States in which current flows into the cell
    function automatic logic drives_current(chg_state_e s);
        return s inside {ST_PRECHG, ST_FAST, ST_TOPOFF, ST_MAINT};
    endfunction

    // Fast charge and cell test share one running phase timer
    function automatic logic keeps_phase(chg_state_e a, chg_state_e b);
        return ((a == ST_FAST) && (b == ST_CTEST)) ||
               ((a == ST_CTEST) && (b == ST_FAST));
    endfunction

endpackage

// File: rtl/chgctl_sec_timer.sv
module chgctl_sec_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    input  logic         tick,
    output logic [W-1:0] cnt
);

    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (en && tick && (cnt != CNT_MAX)) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R7: elapsed seconds never go backwards unless cleared
    a_r7_count_monotonic: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (cnt >= $past(cnt)));

endmodule

// File: rtl/chgctl_next_state.sv
module chgctl_next_state
    import chgctl_pkg::*;
#(
    parameter int TMO_W       = 16,
    parameter int PRE_LIMIT   = 1800,
    parameter int TEST_PERIOD = 31,
    localparam int IW         = $clog2(TEST_PERIOD + 1)
) (
    input  chg_state_e       cur,
    input  sense_t           s,
    input  ctest_t           ct,
    input  logic [TMO_W-1:0] phase_cnt,
    input  logic [IW-1:0]    int_cnt,
    input  logic [TMO_W-1:0] tmo_q,
    output chg_state_e       nxt
);

    localparam logic [TMO_W-1:0] PRE_LIM_V = TMO_W'(PRE_LIMIT);
    localparam logic [IW-1:0]    TEST_V    = IW'(TEST_PERIOD);

    logic ovp, pre_exp, fast_exp, top_exp, test_due;

    always_comb begin
        ovp      = drives_current(cur) ? s.v_charge : s.v_open;
        pre_exp  = (phase_cnt >= PRE_LIM_V);
        fast_exp = (phase_cnt >= tmo_q);
        top_exp  = (phase_cnt >= (tmo_q >> 1));
        test_due = (int_cnt >= TEST_V);
        nxt      = cur;
        if (s.uv) begin
            nxt = ST_RESET;
        end else if (s.tmr_float) begin
            nxt = ST_SUSPEND;
        end else if (is_charging(cur) && ovp) begin
            nxt = ST_FAULT;
        end else begin
            unique case (cur)
                ST_RESET, ST_SUSPEND: nxt = ST_PRESENT;
                ST_PRESENT: begin
                    if (!s.v_open && !s.t_cold && !s.t_hot_ns) nxt = ST_PRECHG;
                end
                ST_PRECHG: begin
                    if (s.t_hot_stop || pre_exp) nxt = ST_FAULT;
                    else if (s.v_low)            nxt = ST_FAST;
                end
                ST_FAST: begin
                    if (s.t_hot_stop)   nxt = ST_MAINT;
                    else if (fast_exp)  nxt = ST_TOPOFF;
                    else if (test_due)  nxt = ST_CTEST;
                end
                ST_CTEST: begin
                    if (ct.fail)        nxt = ST_FAULT;
                    else if (ct.term)   nxt = ST_TOPOFF;
                    else if (ct.pass)   nxt = ST_FAST;
                end
                ST_TOPOFF: begin
                    if (s.t_hot_stop || top_exp) nxt = ST_MAINT;
                end
                ST_MAINT, ST_FAULT: begin
                    if (s.v_charge) nxt = ST_PRESENT;
                end
                default: nxt = ST_RESET;
            endcase
        end
    end

endmodule

// File: rtl/chgctl_top.sv
module chgctl_top
    import chgctl_pkg::*;
#(
    parameter int TMO_W       = 16,
    parameter int PRE_LIMIT   = 1800,
    parameter int TEST_PERIOD = 31
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             uv_lock,
    input  logic             tmr_open,
    input  logic             vcell_gt_open,
    input  logic             vcell_gt_charge,
    input  logic             vcell_gt_low,
    input  logic             temp_cold,
    input  logic             temp_hot_nostart,
    input  logic             temp_hot_stop,
    input  logic             tick_1s,
    input  logic [TMO_W-1:0] fast_tmo_s,
    input  logic             ct_pass,
    input  logic             ct_term,
    input  logic             ct_fail,
    output logic [3:0]       state_code,
    output logic             charge_active
);

    localparam int IW = $clog2(TEST_PERIOD + 1);

    chg_state_e       state_q, state_d;
    sense_t           sense;
    ctest_t           ct;
    logic [TMO_W-1:0] phase_cnt, tmo_q;
    logic [IW-1:0]    int_cnt;
    logic             phase_clr, phase_en, int_clr, int_en;

    assign sense = '{uv: uv_lock, tmr_float: tmr_open, v_open: vcell_gt_open,
                     v_charge: vcell_gt_charge, v_low: vcell_gt_low,
                     t_cold: temp_cold, t_hot_ns: temp_hot_nostart,
                     t_hot_stop: temp_hot_stop};
    assign ct = '{pass: ct_pass, term: ct_term, fail: ct_fail};

    chgctl_next_state #(
        .TMO_W(TMO_W), .PRE_LIMIT(PRE_LIMIT), .TEST_PERIOD(TEST_PERIOD)
    ) u_next (
        .cur(state_q), .s(sense), .ct(ct), .phase_cnt(phase_cnt),
        .int_cnt(int_cnt), .tmo_q(tmo_q), .nxt(state_d)
    );

    assign phase_clr = (state_d != state_q) && !keeps_phase(state_q, state_d);
    assign phase_en  = is_charging(state_q);
    assign int_clr   = (state_q != ST_FAST);
    assign int_en    = (state_q == ST_FAST);

    chgctl_sec_timer #(.W(TMO_W)) u_phase_tmr (
        .clk(clk), .rst(rst), .clr(phase_clr), .en(phase_en),
        .tick(tick_1s), .cnt(phase_cnt)
    );

    chgctl_sec_timer #(.W(IW)) u_test_tmr (
        .clk(clk), .rst(rst), .clr(int_clr), .en(int_en),
        .tick(tick_1s), .cnt(int_cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RESET;
            tmo_q   <= '0;
        end else begin
            state_q <= state_d;
            if ((state_q == ST_PRECHG) && (state_d == ST_FAST)) tmo_q <= fast_tmo_s;
        end
    end

    assign state_code    = state_q;
    assign charge_active = drives_current(state_q);

    // R1: undervoltage forces reset
    a_r1_uv_forces_reset: assert property (@(posedge clk) disable iff (rst)
        uv_lock |=> (state_q == ST_RESET));

    // R2: floating timer pin forces suspend
    a_r2_float_forces_suspend: assert property (@(posedge clk) disable iff (rst)
        (!uv_lock && tmr_open) |=> (state_q == ST_SUSPEND));

    // R10: charging limit applies while current flows
    a_r10_fast_overvolt: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_FAST) && vcell_gt_charge && !uv_lock && !tmr_open)
        |=> (state_q == ST_FAULT));

    // R10: open-circuit limit applies during cell test
    a_r10_ctest_overvolt: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_CTEST) && vcell_gt_open && !uv_lock && !tmr_open)
        |=> (state_q == ST_FAULT));

    // R11: removal releases fault and maintenance
    a_r11_removal_release: assert property (@(posedge clk) disable iff (rst)
        (((state_q == ST_FAULT) || (state_q == ST_MAINT)) && vcell_gt_charge
         && !uv_lock && !tmr_open) |=> (state_q == ST_PRESENT));

    // R12: fault beats completion in precharge
    a_r12_fault_wins: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_PRECHG) && vcell_gt_low && temp_hot_stop
         && !uv_lock && !tmr_open) |=> (state_q == ST_FAULT));

    // R6: cell test is entered only from fast charge
    a_r6_ctest_entry: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_CTEST) && !$past(state_q == ST_CTEST))
        |-> $past(state_q == ST_FAST));

endmodule

// File: tb/chgctl_top_test.sv
`timescale 1ns/1ps
module chgctl_top_test;

    localparam int PRE_LIM = 12;
    localparam int TPER    = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic uv = 0, tmr = 0, v_open = 1, v_chg = 0, v_low = 0;
    logic t_cold = 0, t_hns = 0, t_hs = 0, tick = 0;
    logic [15:0] tmo = 16'd100;
    logic c_pass = 0, c_term = 0, c_fail = 0;
    logic [3:0] st;
    logic act;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    chgctl_top #(.TMO_W(16), .PRE_LIMIT(PRE_LIM), .TEST_PERIOD(TPER)) uut (
        .clk(clk), .rst(rst), .uv_lock(uv), .tmr_open(tmr),
        .vcell_gt_open(v_open), .vcell_gt_charge(v_chg), .vcell_gt_low(v_low),
        .temp_cold(t_cold), .temp_hot_nostart(t_hns), .temp_hot_stop(t_hs),
        .tick_1s(tick), .fast_tmo_s(tmo), .ct_pass(c_pass), .ct_term(c_term),
        .ct_fail(c_fail), .state_code(st), .charge_active(act)
    );

    function automatic logic exp_active(logic [3:0] s);
        return (s == 4'd2) || (s == 4'd3) || (s == 4'd5) || (s == 4'd6);
    endfunction

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic sec();
        tick = 1; cyc(); tick = 0; cyc();
    endtask

    task automatic chk(string tag, int actual, int expected);
        n_chk++;
        if (actual != expected) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
        end
    endtask

    task automatic chk_st(string tag, int expected);
        chk(tag, int'(st), expected);
    endtask

    // From presence (v_open low, temps fine) into precharge
    task automatic to_pre();
        v_open = 0; cyc(); chk_st("R3 enter precharge", 2);
    endtask

    task automatic to_fast(int t);
        tmo = 16'(t); v_low = 1; cyc(); v_low = 0;
        chk_st("R4 enter fast", 3);
    endtask

    // Removal from fault or maintenance, then back into precharge
    task automatic recover();
        t_hs = 0; v_open = 1; v_chg = 1; cyc(); chk_st("R11 removal", 1);
        v_chg = 0; v_open = 0; cyc();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        cyc(); cyc();
        chk_st("R1 reset state", 0);
        chk("R10 inactive in reset", int'(act), 0);
        rst = 0; cyc();
        chk_st("R1 reset to presence", 1);

        // R3 qualification
        cyc(); chk_st("R3 open socket holds", 1);
        v_open = 0; t_cold = 1; cyc(); chk_st("R3 cold holds", 1);
        t_cold = 0; t_hns = 1; cyc(); chk_st("R3 hot holds", 1);
        t_hns = 0; cyc(); chk_st("R3 start precharge", 2);
        chk("R10 active in precharge", int'(act), 1);

        // R5 precharge timeout
        for (int i = 0; i < PRE_LIM - 1; i++) sec();
        chk_st("R5 one second early", 2);
        sec(); chk_st("R5 precharge timeout", 7);
        chk("R10 inactive in fault", int'(act), 0);
        v_open = 1; cyc(); chk_st("R11 open flag ignored in fault", 7);
        recover(); chk_st("R3 restart precharge", 2);

        // R1 undervoltage clears timers
        for (int i = 0; i < 8; i++) sec();
        uv = 1; tmr = 1; cyc(); chk_st("R1 uv over float", 0);
        uv = 0; tmr = 0; cyc(); chk_st("R1 leave reset", 1);
        cyc(); chk_st("R1 precharge again", 2);
        for (int i = 0; i < PRE_LIM - 1; i++) sec();
        chk_st("R1 timer was cleared", 2);
        sec(); chk_st("R5 full limit after reset", 7);
        recover();

        // R12 fault wins over completion
        v_low = 1; t_hs = 1; cyc(); chk_st("R12 hot stop beats fast entry", 7);
        v_low = 0; recover();

        // R6 cell test outcomes
        to_fast(100);
        for (int i = 0; i < TPER - 1; i++) sec();
        chk_st("R6 before interval", 3);
        sec(); chk_st("R6 cell test due", 4);
        chk("R10 inactive in cell test", int'(act), 0);
        c_pass = 1; cyc(); c_pass = 0; chk_st("R6 pass returns", 3);
        for (int i = 0; i < TPER; i++) sec();
        chk_st("R6 second cell test", 4);
        c_fail = 1; c_term = 1; cyc(); c_fail = 0; c_term = 0;
        chk_st("R6 fail wins over term", 7);
        recover();
        to_fast(100);
        for (int i = 0; i < TPER; i++) sec();
        c_term = 1; cyc(); c_term = 0; chk_st("R6 term to top-off", 5);
        chk("R10 active in top-off", int'(act), 1);

        // R9 hot stop in top-off and fast
        t_hs = 1; cyc(); chk_st("R9 top-off hot stop", 6);
        chk("R10 active in maintenance", int'(act), 1);
        t_hs = 0; v_open = 1; cyc(); chk_st("R11 maintenance holds", 6);
        recover();
        to_fast(100);
        t_hs = 1; cyc(); chk_st("R9 fast hot stop", 6);
        recover();

        // R10 limit selection
        to_fast(100);
        v_open = 1; cyc(); chk_st("R10 open limit ignored while charging", 3);
        v_chg = 1; cyc(); chk_st("R10 charge limit fault", 7);
        v_chg = 0; recover();
        to_fast(100);
        for (int i = 0; i < TPER; i++) sec();
        v_open = 1; cyc(); chk_st("R10 open limit in cell test", 7);
        recover();

        // R2 suspend
        tmr = 1; cyc(); chk_st("R2 suspend", 8);
        chk("R10 inactive in suspend", int'(act), 0);
        cyc(); chk_st("R2 suspend holds", 8);
        tmr = 0; cyc(); chk_st("R2 leave suspend", 1);
        cyc(); chk_st("R2 precharge after suspend", 2);

        // R7 and R8 with random timeouts
        for (int k = 0; k < 4; k++) begin
            automatic int t = $urandom_range(36, 6);
            automatic int n = 0;
            to_fast(t);
            while (st != 4'd5 && n < 300) begin
                sec(); n++;
                if (st == 4'd4) begin
                    c_pass = 1; cyc(); c_pass = 0;
                end
            end
            chk("R7 fast timeout seconds", n, t);
            n = 0;
            while (st == 4'd5 && n < 300) begin
                sec(); n++;
            end
            chk("R8 top-off seconds", n, t >> 1);
            chk_st("R8 reaches maintenance", 6);
            recover();
        end

        // R1 and R2 random override from varied states
        for (int k = 0; k < 8; k++) begin
            automatic int r = $urandom_range(2, 0);
            repeat ($urandom_range(5, 0)) sec();
            uv  = (r != 1);
            tmr = (r != 0);
            cyc();
            chk_st(uv ? "R1 random uv" : "R2 random float", uv ? 0 : 8);
            chk("R10 random override inactive", int'(act), int'(exp_active(st)));
            uv = 0; tmr = 0; cyc(); chk_st("R2 random release", 1);
            cyc();
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule